// File: doc/BRIEF.md
# Compressed Index Vector Generator

This block builds a packed vector of element offsets from a 64-bit element mask. A start strobe supplies the mask, an active length, a polarity bit, a 32-bit scalar stride and a destination vector register number. The block walks the qualified element positions from the lowest upward. For each selected position `i` it issues one write of `i * stride` to the register file. Writes land in consecutive destination slots starting at slot 0, and the number of elements produced is returned as a count.

The packed result is intended to serve as the offset operand of later gather and scatter memory operations. The count is written to a separate vector count register. Only the selected indices appear in the output, so the destination holds no gaps. The polarity bit lets one mask serve both arms of an if/else construct. Slots at or above the count are never written.

Top module: `ciota_gen`

## Requirements
- R1: After reset the block is idle: `busy_o`, `wr_en_o` and `done_o` are 0 and `count_o` is 0.
- R2: Element position `i` is selected exactly when `i` is below the captured length and `mask_i[i]` equals `pol_i`. With `pol_i`=1 a set mask bit selects; with `pol_i`=0 a clear bit selects.
- R3: Starting in the cycle after an accepted start, the block issues one write per cycle on consecutive cycles. The writes go to register `dst_i` at slots 0, 1, 2, … in order. Selected positions are emitted in ascending order, and `busy_o` is 1 from that cycle through the `done_o` cycle.
- R4: Each written element has `wr_data_o[31:0]` equal to `(i * stride_i) mod 2^32` for its position `i`, and `wr_data_o[63:32]` equal to 0.
- R5: `done_o` is a single-cycle pulse in the cycle right after the last write, with no write in that cycle. In that cycle `count_o` equals the number of writes made.
- R6: With no selected element, no write occurs. `done_o` rises in the cycle after the start with `count_o` = 0.
- R7: A length value of 64 or more makes all 64 positions eligible.
- R8: A start strobe while `busy_o` is 1 is ignored: the running operation's writes, register and count are unchanged.
- R9: `count_o` keeps its value while the block is idle and no start arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| mask_i | input | 64 | Element mask, bit i for position i |
| vlen_i | input | 7 | Active length |
| pol_i | input | 1 | Mask value that marks a selected element |
| stride_i | input | 32 | Scalar multiplier for each index |
| dst_i | input | 4 | Destination vector register number |
| busy_o | output | 1 | Operation in progress |
| wr_en_o | output | 1 | Register-file write enable |
| wr_reg_o | output | 4 | Register-file write register number |
| wr_idx_o | output | 6 | Register-file write slot |
| wr_data_o | output | 64 | Register-file write data |
| done_o | output | 1 | Completion pulse |
| count_o | output | 7 | Number of elements generated |

## Verification
The bench targets empty selections from a zero mask, from a zero length and from the wrong polarity. A design that got these wrong would write a stray element or delay `done_o`. Other cases are a full 64-element run and lengths above 64. A wrong length compare would drop or add positions there, or overflow the slot index. A stride of all ones exposes products that are truncated wrongly or leak into the upper half. A restart strobe issued mid-run would, in a faulty design, switch the destination register or reset the slot sequence.

// File: rtl/ciota_pkg.sv
package ciota_pkg;
    localparam int unsigned CI_ELEMS    = 64;
    localparam int unsigned CI_STRIDE_W = 32;
    localparam int unsigned CI_DATA_W   = 64;
    localparam int unsigned CI_REG_W    = 4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } ciota_st_e;
endpackage

// File: rtl/ciota_qualify.sv
module ciota_qualify #(
    parameter int unsigned NE = 64,
    parameter int unsigned LW = $clog2(NE) + 1
) (
    input  logic [NE-1:0] mask_i,
    input  logic [LW-1:0] vlen_i,
    input  logic          pol_i,
    output logic [NE-1:0] sel_o
);
    // a position qualifies when its mask bit matches the polarity and it lies below the length
    for (genvar i = 0; i < NE; i++) begin : g_pos
        assign sel_o[i] = (mask_i[i] == pol_i) && (LW'(i) < vlen_i);
    end
endmodule

// File: rtl/ciota_pick.sv
module ciota_pick #(
    parameter int unsigned NE = 64,
    parameter int unsigned IW = $clog2(NE)
) (
    input  logic [NE-1:0] vec_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    // lowest set position wins
    always_comb begin
        idx_o = '0;
        for (int i = NE - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
    end
    assign any_o = |vec_i;
endmodule

// File: rtl/ciota_scale.sv
module ciota_scale #(
    parameter int unsigned IW = 6,
    parameter int unsigned SW = 32,
    parameter int unsigned DW = 64
) (
    input  logic [IW-1:0] idx_i,
    input  logic [SW-1:0] stride_i,
    output logic [DW-1:0] data_o
);
    logic [SW-1:0] prod_lo;
    // product kept modulo 2^SW; upper part of the element cleared
    assign prod_lo = SW'(idx_i) * stride_i;
    assign data_o  = {{(DW - SW){1'b0}}, prod_lo};
endmodule

// File: rtl/ciota_gen.sv
module ciota_gen
    import ciota_pkg::*;
#(
    parameter int unsigned NE = CI_ELEMS,
    parameter int unsigned SW = CI_STRIDE_W,
    parameter int unsigned DW = CI_DATA_W,
    parameter int unsigned RW = CI_REG_W,
    localparam int unsigned IW = $clog2(NE),
    localparam int unsigned LW = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [NE-1:0] mask_i,
    input  logic [LW-1:0] vlen_i,
    input  logic          pol_i,
    input  logic [SW-1:0] stride_i,
    input  logic [RW-1:0] dst_i,
    output logic          busy_o,
    output logic          wr_en_o,
    output logic [RW-1:0] wr_reg_o,
    output logic [IW-1:0] wr_idx_o,
    output logic [DW-1:0] wr_data_o,
    output logic          done_o,
    output logic [LW-1:0] count_o
);
    typedef struct packed {
        ciota_st_e     st;
        logic [NE-1:0] rem;
        logic [RW-1:0] dst;
        logic [SW-1:0] stride;
        logic [LW-1:0] cnt;
    } ciota_state_t;

    ciota_state_t s_d, s_q;

    logic [NE-1:0] sel_mask;
    logic          pick_any;
    logic [IW-1:0] pick_idx;

    ciota_qualify #(.NE(NE), .LW(LW)) u_qual (
        .mask_i (mask_i),
        .vlen_i (vlen_i),
        .pol_i  (pol_i),
        .sel_o  (sel_mask)
    );

    ciota_pick #(.NE(NE), .IW(IW)) u_pick (
        .vec_i (s_q.rem),
        .any_o (pick_any),
        .idx_o (pick_idx)
    );

    ciota_scale #(.IW(IW), .SW(SW), .DW(DW)) u_scale (
        .idx_i    (pick_idx),
        .stride_i (s_q.stride),
        .data_o   (wr_data_o)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.st     = ST_SCAN;
                    s_d.rem    = sel_mask;
                    s_d.dst    = dst_i;
                    s_d.stride = stride_i;
                    s_d.cnt    = '0;
                end
            end
            ST_SCAN: begin
                if (pick_any) begin
                    s_d.rem = s_q.rem & ~({{(NE - 1){1'b0}}, 1'b1} << pick_idx);
                    s_d.cnt = s_q.cnt + 1'b1;
                end else begin
                    s_d.st = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, rem: '0, dst: '0, stride: '0, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o   = (s_q.st == ST_SCAN);
    assign wr_en_o  = busy_o && pick_any;
    assign done_o   = busy_o && !pick_any;
    assign wr_reg_o = s_q.dst;
    assign wr_idx_o = s_q.cnt[IW-1:0];
    assign count_o  = s_q.cnt;

    // R3: writes happen only while busy
    a_r3_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> busy_o);

    // R3: slots advance by one on back-to-back writes
    a_r3_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && $past(wr_en_o)) |-> (wr_idx_o == IW'($past(wr_idx_o) + 1'b1)));

    // R3: chosen element positions strictly ascend
    a_r3_pos_ascend: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && $past(wr_en_o)) |-> (pick_idx > $past(pick_idx)));

    // R5: done is a single pulse and carries no write
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r5_done_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !wr_en_o);

    // R8: a strobe during a run leaves the target register alone
    a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> $stable(wr_reg_o));

    // R9: idle count is held
    a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(count_o));
endmodule

// File: tb/sim_ciota_gen.sv
module sim_ciota_gen;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] mask_i = '0;
    logic [6:0]  vlen_i = '0;
    logic        pol_i = 1'b1;
    logic [31:0] stride_i = '0;
    logic [3:0]  dst_i = '0;
    logic        busy_o, wr_en_o, done_o;
    logic [3:0]  wr_reg_o;
    logic [5:0]  wr_idx_o;
    logic [63:0] wr_data_o;
    logic [6:0]  count_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ciota_gen u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i),
        .vlen_i(vlen_i), .pol_i(pol_i), .stride_i(stride_i), .dst_i(dst_i),
        .busy_o(busy_o), .wr_en_o(wr_en_o), .wr_reg_o(wr_reg_o),
        .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o), .done_o(done_o),
        .count_o(count_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            checks++;
            $display("FAIL R3 watchdog actual=%0d expected=%0d", cyc, 50000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // behavioural model: list of selected positions, then cycle-by-cycle compare
    task automatic run(input logic [63:0] m, input int len, input bit pol,
                       input logic [31:0] str, input logic [3:0] dst,
                       input bit poke_busy, input string req);
        int sel[$];
        int lim;
        lim = (len > 64) ? 64 : len;
        for (int i = 0; i < lim; i++) if (m[i] == pol) sel.push_back(i);
        @(negedge clk);
        mask_i = m; vlen_i = 7'(len); pol_i = pol; stride_i = str; dst_i = dst;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        mask_i = ~m; dst_i = ~dst; stride_i = ~str;
        for (int k = 0; k <= sel.size(); k++) begin
            chk(busy_o == 1'b1, req, "busy", busy_o, 1);
            if (k < sel.size()) begin
                logic [63:0] ed;
                ed = {32'h0, 32'(longint'(sel[k]) * longint'(str))};
                chk(wr_en_o == 1'b1, req, "wr_en", wr_en_o, 1);
                chk(done_o == 1'b0, "R5", "early done", done_o, 0);
                chk(wr_idx_o == 6'(k), "R3", "slot", wr_idx_o, k);
                chk(wr_reg_o == dst, "R3", "reg", wr_reg_o, dst);
                chk(wr_data_o == ed, "R4", "data", wr_data_o, ed);
            end else begin
                chk(wr_en_o == 1'b0, "R5", "write at done", wr_en_o, 0);
                chk(done_o == 1'b1, req, "done", done_o, 1);
                chk(count_o == 7'(sel.size()), "R5", "count", count_o, sel.size());
            end
            @(negedge clk);
            if (poke_busy && k == 0) start_i = 1'b1;
            else start_i = 1'b0;
        end
        start_i = 1'b0;
        chk(busy_o == 1'b0, req, "idle after", busy_o, 0);
        chk(done_o == 1'b0, "R5", "done pulse", done_o, 0);
        repeat (2) @(negedge clk);
        chk(count_o == 7'(sel.size()), "R9", "count held", count_o, sel.size());
        chk(wr_en_o == 1'b0, "R9", "idle write", wr_en_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0, "R1", "busy", busy_o, 0);
        chk(wr_en_o == 1'b0, "R1", "wr_en", wr_en_o, 0);
        chk(done_o == 1'b0, "R1", "done", done_o, 0);
        chk(count_o == 7'd0, "R1", "count", count_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run(64'hFFFF_FFFF_FFFF_FFFF, 64, 1'b1, 32'd1, 4'd3, 1'b0, "R3");
        run(64'hA5A5_0F0F_3C3C_9669, 37, 1'b1, 32'd8, 4'd7, 1'b0, "R2");
        run(64'hA5A5_0F0F_3C3C_9669, 37, 1'b0, 32'd8, 4'd9, 1'b0, "R2");
        run(64'h0, 64, 1'b1, 32'd4, 4'd1, 1'b0, "R6");
        run(64'hFFFF_FFFF_FFFF_FFFF, 0, 1'b1, 32'd4, 4'd2, 1'b0, "R6");
        run(64'hFFFF_FFFF_FFFF_FFFF, 64, 1'b0, 32'd4, 4'd2, 1'b0, "R6");
        run(64'h8000_0000_0000_0001, 100, 1'b1, 32'd12, 4'd5, 1'b0, "R7");
        run(64'h8000_0000_0000_0000, 127, 1'b1, 32'd3, 4'd6, 1'b0, "R7");
        run(64'hF000_0000_0000_00F6, 64, 1'b1, 32'hFFFF_FFFF, 4'd15, 1'b0, "R4");
        run(64'h0000_0000_0000_0F0F, 20, 1'b1, 32'h1234_5678, 4'd4, 1'b1, "R8");
        run(64'h0000_0000_00FF_0000, 24, 1'b1, 32'd2, 4'd0, 1'b1, "R8");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule